// File: doc/BRIEF.md
# Phase-Gated Time Interval Counter

This block measures how far a local one-pulse-per-second signal sits from a reference one. An external phase detector produces a pulse whose width equals the offset between the two. The block runs a fast counter on a clock that is never gated. The phase-detector pulse only enables that counter, after it passes through a two-stage synchronizer. At 100 MHz, for example, each count stands for 10 ns.

Once per second a sample strobe captures the count as that second's reading and clears the counter on the same edge. The readings are summed over an update window whose length is set in seconds. A typical setting is 120 s; 30 s is a shorter choice. When the window closes, the block presents the sum together with a one-cycle valid pulse.

The phase range is kept small on purpose, so a reading is capped at a parameterised limit. Any reading that hits this cap raises a flag that stays set for the rest of the window.

Top module: `phase_tic`

## Requirements
- R1: While `rst_n` is low, `sec_count`, `acc_sum`, `sum_valid` and `over_range` are all zero, and the internal count and window position are cleared.
- R2: `gate_async` passes through two flip-flop stages before it enables counting. A gate that is high for N consecutive clock edges, well away from a strobe, adds exactly N to the running count.
- R3: While the synchronized gate is low the running count does not change. A second with no gate activity reads 0.
- R4: On the clock edge where `sample_stb` is high, `sec_count` takes the running count and the counter restarts. If the enable is active on that edge, it counts as 1 in the new second. No count is lost when a gate pulse spans the strobe.
- R5: `sec_count` never exceeds the parameter `RANGE_MAX`. A second whose count would pass the limit reads exactly `RANGE_MAX`.
- R6: `over_range` rises on the strobe of a saturated reading. It stays high through the remaining strobes of that window and during the update. The first strobe of the next window reloads it from that strobe's reading alone.
- R7: On the strobe that ends a window, `sum_valid` is high for exactly one cycle. On that same edge `acc_sum` shows the sum of all of the window's readings, including the reading taken on that edge, and the internal sum restarts from zero.
- R8: A window ends on the strobe that counts second number `period_sec` of the window. A `period_sec` of 0 is treated as 1, so every strobe ends a window.
- R9: `acc_sum` and `sec_count` hold their values between the edges that update them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running count clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| gate_async | input | 1 | Phase-detector pulse, asynchronous to clk |
| sample_stb | input | 1 | One-cycle once-per-second read/clear strobe |
| period_sec | input | PER_W | Update window length in seconds (0 behaves as 1) |
| sec_count | output | CNT_W | Reading of the last completed second |
| acc_sum | output | SUM_W | Sum of readings over the last completed window |
| sum_valid | output | 1 | One-cycle pulse when `acc_sum` is updated |
| over_range | output | 1 | Sticky flag: a reading in this window was saturated |

## Verification
A gate change on `gate_async` reaches the count enable two edges later, and the count it enables lands on the edge after that. The bench therefore leaves at least four idle cycles between dropping the gate and raising the strobe. `sec_count`, `acc_sum`, `sum_valid` and `over_range` all change on the strobe edge itself, so the bench reads them at the falling edge right after it. It checks one falling edge later that `sum_valid` has dropped again. For a gate that spans the strobe, the split between the two readings depends on the synchronizer delay. Only their sum is compared, since that total is fixed by the number of gated cycles.

// File: rtl/phase_tic.sv
module phase_tic #(
  parameter int          CNT_W     = 16,
  parameter int          SUM_W     = 32,
  parameter int          PER_W     = 8,
  parameter int unsigned RANGE_MAX = 12288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_async,
  input  logic             sample_stb,
  input  logic [PER_W-1:0] period_sec,
  output logic [CNT_W-1:0] sec_count,
  output logic [SUM_W-1:0] acc_sum,
  output logic             sum_valid,
  output logic             over_range
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RANGE_MAX);

  logic             gate_meta, gate_en;
  logic [CNT_W-1:0] run_cnt;
  logic [PER_W-1:0] sec_idx;
  logic [SUM_W-1:0] acc;

  wire              over_now   = run_cnt > LIMIT;
  wire [CNT_W-1:0]  reading    = over_now ? LIMIT : run_cnt;
  wire [PER_W-1:0]  last_idx   = (period_sec == '0) ? '0 : period_sec - PER_W'(1);
  wire              window_end = sec_idx >= last_idx;
  wire              first_sec  = sec_idx == '0;
  wire [SUM_W-1:0]  acc_next   = acc + SUM_W'(reading);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate_meta <= 1'b0;
      gate_en   <= 1'b0;
    end else begin
      gate_meta <= gate_async;
      gate_en   <= gate_meta;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (sample_stb)
      run_cnt <= gate_en ? CNT_W'(1) : '0;
    else if (gate_en && !over_now)
      run_cnt <= run_cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_count  <= '0;
      over_range <= 1'b0;
    end else if (sample_stb) begin
      sec_count  <= reading;
      over_range <= over_now | (over_range & ~first_sec);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_idx   <= '0;
      acc       <= '0;
      acc_sum   <= '0;
      sum_valid <= 1'b0;
    end else begin
      sum_valid <= 1'b0;
      if (sample_stb) begin
        if (window_end) begin
          acc_sum   <= acc_next;
          sum_valid <= 1'b1;
          acc       <= '0;
          sec_idx   <= '0;
        end else begin
          acc     <= acc_next;
          sec_idx <= sec_idx + PER_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/phase_tic_chk.sv
module phase_tic_chk #(
  parameter int          CNT_W     = 16,
  parameter int          SUM_W     = 32,
  parameter int          PER_W     = 8,
  parameter int unsigned RANGE_MAX = 12288
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sample_stb,
  input logic [CNT_W-1:0] sec_count,
  input logic [SUM_W-1:0] acc_sum,
  input logic             sum_valid,
  input logic             over_range
);

  // R5
  range_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_count <= CNT_W'(RANGE_MAX));

  // R7
  valid_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> $past(sample_stb));

  // R9
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_valid |-> $stable(acc_sum));

  // R4
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_stb) |-> $stable(sec_count));

  // R6
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(over_range) |-> (sec_count == CNT_W'(RANGE_MAX)));

  // R6
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_stb) |-> $stable(over_range));

endmodule

bind phase_tic phase_tic_chk #(
  .CNT_W(CNT_W), .SUM_W(SUM_W), .PER_W(PER_W), .RANGE_MAX(RANGE_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
  .sec_count(sec_count), .acc_sum(acc_sum),
  .sum_valid(sum_valid), .over_range(over_range)
);

// File: tb/phase_tic_test.sv
module phase_tic_test;
  localparam int CNT_W = 16, SUM_W = 32, PER_W = 8;
  localparam int MAXC  = 200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             gate_async = 1'b0;
  logic             sample_stb = 1'b0;
  logic [PER_W-1:0] period_sec = 8'd1;
  logic [CNT_W-1:0] sec_count;
  logic [SUM_W-1:0] acc_sum;
  logic             sum_valid;
  logic             over_range;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int m_idx = 0, m_acc = 0, m_last_sum = 0, m_last_cnt = 0;
  bit m_ovr = 1'b0;

  always #2 clk = ~clk;

  phase_tic #(.CNT_W(CNT_W), .SUM_W(SUM_W), .PER_W(PER_W), .RANGE_MAX(MAXC)) uut (
    .clk(clk), .rst_n(rst_n), .gate_async(gate_async), .sample_stb(sample_stb),
    .period_sec(period_sec), .sec_count(sec_count), .acc_sum(acc_sum),
    .sum_valid(sum_valid), .over_range(over_range)
  );

  function automatic int cap(input int n);
    return (n > MAXC) ? MAXC : n;
  endfunction

  function automatic int eff_period(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic one_sec(input int n);
    int  rd;
    bit  fin;
    repeat (2) @(negedge clk);
    if (n > 0) begin
      gate_async = 1'b1;
      repeat (n) @(negedge clk);
      gate_async = 1'b0;
    end
    repeat (4) @(negedge clk);
    check("R9 sec_count held", sec_count, m_last_cnt);
    check("R9 acc_sum held", acc_sum, m_last_sum);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    rd  = cap(n);
    fin = (m_idx + 1 >= eff_period(period_sec));
    m_ovr = (n > MAXC) | (m_ovr & (m_idx != 0));
    check(n == 0 ? "R3 idle second" : (n > MAXC ? "R5 saturated reading" : "R2 gated count"),
          sec_count, rd);
    check("R6 over_range", over_range, m_ovr);
    check("R8 window end", sum_valid, fin);
    m_acc += rd;
    m_last_cnt = rd;
    if (fin) begin
      check("R7 window sum", acc_sum, m_acc);
      m_last_sum = m_acc;
      m_acc = 0;
      m_idx = 0;
    end else begin
      m_idx++;
    end
    @(negedge clk);
    check("R7 one-cycle valid", sum_valid, 0);
  endtask

  initial begin
    void'($urandom(32'd20070720));
    repeat (3) @(negedge clk);
    check("R1 sec_count reset", sec_count, 0);
    check("R1 acc_sum reset", acc_sum, 0);
    check("R1 sum_valid reset", sum_valid, 0);
    check("R1 over_range reset", over_range, 0);
    rst_n = 1'b1;

    // R4: gate held high across a strobe, 20 gated edges in total
    period_sec = 8'd2;
    @(negedge clk);
    gate_async = 1'b1;
    repeat (10) @(negedge clk);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    m_last_cnt = sec_count;
    check("R8 no valid mid-window", sum_valid, 0);
    repeat (9) @(negedge clk);
    gate_async = 1'b0;
    repeat (4) @(negedge clk);
    sample_stb = 1'b1;
    @(negedge clk);
    sample_stb = 1'b0;
    check("R4 no count lost across strobe", sec_count + m_last_cnt, 20);
    check("R4 window sum across strobe", acc_sum, 20);
    check("R7 valid at window end", sum_valid, 1);
    m_last_cnt = sec_count;
    m_last_sum = acc_sum;

    // directed corner cases
    period_sec = 8'd3;
    one_sec(0);
    one_sec(MAXC);
    one_sec(MAXC + 1);
    period_sec = 8'd3;
    one_sec(5);
    one_sec(7);
    one_sec(9);
    period_sec = 8'd0;
    one_sec(12);
    one_sec(MAXC + 40);
    one_sec(3);

    // randomized windows
    for (int w = 0; w < 20; w++) begin
      period_sec = PER_W'($urandom_range(0, 6));
      for (int s = 0; s < eff_period(period_sec); s++)
        one_sec(($urandom_range(0, 9) == 0) ? $urandom_range(MAXC + 1, MAXC + 60)
                                            : $urandom_range(0, MAXC));
    end

    // long default window
    period_sec = 8'd120;
    for (int s = 0; s < 120; s++) one_sec($urandom_range(0, 20));

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule